// File: doc/BRIEF.md
# Cache Access Blocking Cause Tracker

This block keeps track of why the request path on the processor side of a cache is closed. Other parts of the cache raise or drop individual blocking reasons with a set strobe and a clear strobe, each carrying a cause index. The tracker holds one bit per reason. The path is closed while any bit is set. While the path is closed, incoming requests are refused, and the tracker remembers that a retry is owed.

The tracker only takes note of the moments when the whole set of reasons goes from empty to non-empty, or back again. On the first kind of moment it counts a blocking episode against the cause that opened it, and it stamps the start time from a free-running cycle counter input. On the second kind it adds the elapsed cycles to the accumulator of the cause that closed the episode. One cycle after the path reopens, a single retry pulse goes out, but only if some request was refused during the episode. All counters stop at their maximum value rather than wrapping.

Top module: `blk_cause_tracker`

## Requirements
- R1: Cause indices are 0 (no free miss-status entry), 1 (no free write-buffer entry) and 2 (no free target slot in an entry). A set strobe with a valid index makes bit `cause_mask[index]` read 1 from the cycle after the strobe.
- R2: A clear strobe with a valid index makes that bit read 0 from the next cycle. If a set strobe and a clear strobe name the same cause in the same cycle, the bit ends up set.
- R3: `blocked` is 1 exactly when `cause_mask` is non-zero, and `req_ready` is its inverse.
- R4: When a set strobe finds the mask empty, the episode counter of that cause (`evt_cnt[c*CNT_W +: CNT_W]`) rises by one. The value of `cycle_now` at that edge is kept as the episode start time.
- R5: A set strobe that finds the mask already non-empty changes no episode counter, no accumulator and no start time.
- R6: When a clear strobe empties the mask, `(cycle_now - start) mod 2^CYC_W` is added to the accumulator of the clearing cause (`blk_cycles[c*ACC_W +: ACC_W]`). The other accumulators keep their values.
- R7: A request offered while `blocked` is 1 is refused and records an owed retry. `retry` is then a one-cycle pulse at the first clock edge at which `blocked` was 0 and a retry was owed, and this clears the owed flag. Without a refused request, no pulse is produced.
- R8: Episode counters and accumulators stay at their all-ones value instead of wrapping.
- R9: Synchronous reset clears the mask, all counters and accumulators, and the owed-retry flag. After reset, `retry` is 0.
- R10: A set or clear strobe whose index is not below the number of causes (index 3) has no effect on the mask or on the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_now | input | CYC_W | Free-running cycle count used for time stamps |
| set_valid | input | 1 | Raise a blocking cause |
| set_cause | input | IDX_W | Index of the cause to raise |
| clr_valid | input | 1 | Drop a blocking cause |
| clr_cause | input | IDX_W | Index of the cause to drop |
| req_valid | input | 1 | A request is offered on the processor side |
| blocked | output | 1 | Request path closed |
| req_ready | output | 1 | Request path open |
| retry | output | 1 | One-cycle retry pulse to refused requesters |
| cause_mask | output | NUM_CAUSES | Current set of active causes |
| evt_cnt | output | NUM_CAUSES*CNT_W | Per-cause blocking episode counts |
| blk_cycles | output | NUM_CAUSES*ACC_W | Per-cause accumulated blocked cycles |

## Verification
The properties assume that `cycle_now` advances by at most the counter range between the opening and closing of an episode, so the modular difference is the true duration. They also assume that strobes are sampled only at clock edges. The counter non-decrease property relies on reset being the only way a count can fall. The stimulus drives `cycle_now` as a plain incrementing count that starts just below its wrap point, so an episode spans the wrap without ever exceeding the range. Strobes and requests change only between edges, both in the random mix and in the directed cases, and the random mix also sends the invalid cause index.

// File: rtl/bt_pkg.sv
package bt_pkg;
  // Cause encoding; the bit position in the mask equals the value.
  typedef enum logic [1:0] {
    CAUSE_MISS_FULL = 2'd0,
    CAUSE_WBUF_FULL = 2'd1,
    CAUSE_TGT_FULL  = 2'd2
  } blk_cause_e;

  localparam int unsigned DEF_NUM_CAUSES = 3;
endpackage

// File: rtl/bt_mask_track.sv
module bt_mask_track #(
  parameter int unsigned NUM_CAUSES = 3,
  parameter int unsigned IDX_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_valid,
  input  logic [IDX_W-1:0]      set_cause,
  input  logic                  clr_valid,
  input  logic [IDX_W-1:0]      clr_cause,
  output logic [NUM_CAUSES-1:0] mask_q,
  output logic                  begin_evt,
  output logic                  end_evt
);
  // One-hot decode; indices outside the cause range decode to nothing.
  function automatic logic [NUM_CAUSES-1:0] cause_bit(input logic v,
                                                      input logic [IDX_W-1:0] idx);
    logic [NUM_CAUSES-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CAUSES; i++) begin
      if (v && (idx == IDX_W'(i))) r[i] = 1'b1;
    end
    return r;
  endfunction

  logic [NUM_CAUSES-1:0] set_bits, clr_bits, mask_d;

  always_comb begin
    set_bits = cause_bit(set_valid, set_cause);
    clr_bits = cause_bit(clr_valid, clr_cause);
    // Clear first, then set: set wins for the same cause.
    mask_d   = (mask_q & ~clr_bits) | set_bits;
  end

  assign begin_evt = (mask_q == '0) && (mask_d != '0);
  assign end_evt   = (mask_q != '0) && (mask_d == '0);

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end
endmodule

// File: rtl/bt_cause_stats.sv
module bt_cause_stats #(
  parameter int unsigned NUM_CAUSES = 3,
  parameter int unsigned IDX_W      = 2,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned CYC_W      = 32,
  parameter int unsigned ACC_W      = 40
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CYC_W-1:0]            cycle_now,
  input  logic                        begin_evt,
  input  logic [IDX_W-1:0]            begin_cause,
  input  logic                        end_evt,
  input  logic [IDX_W-1:0]            end_cause,
  output logic [NUM_CAUSES*CNT_W-1:0] evt_cnt,
  output logic [NUM_CAUSES*ACC_W-1:0] blk_cycles
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ACC_W] ? '1 : s[ACC_W-1:0];
  endfunction

  function automatic logic [CYC_W-1:0] span(input logic [CYC_W-1:0] now,
                                            input logic [CYC_W-1:0] start);
    return now - start;
  endfunction

  logic [CYC_W-1:0] start_q;
  logic [ACC_W-1:0] elapsed;

  assign elapsed = ACC_W'(span(cycle_now, start_q));

  always_ff @(posedge clk) begin
    if (rst)            start_q <= '0;
    else if (begin_evt) start_q <= cycle_now;
  end

  for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_cause
    logic [CNT_W-1:0] evt_q;
    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        evt_q <= '0;
        acc_q <= '0;
      end else begin
        if (begin_evt && (begin_cause == IDX_W'(g))) evt_q <= sat_inc(evt_q);
        if (end_evt && (end_cause == IDX_W'(g)))     acc_q <= sat_add(acc_q, elapsed);
      end
    end

    assign evt_cnt[g*CNT_W +: CNT_W]    = evt_q;
    assign blk_cycles[g*ACC_W +: ACC_W] = acc_q;
  end
endmodule

// File: rtl/bt_retry.sv
module bt_retry (
  input  logic clk,
  input  logic rst,
  input  logic blocked,
  input  logic req_valid,
  output logic refused,
  output logic retry
);
  logic owed_q;
  logic fire;

  assign refused = req_valid && blocked;
  assign fire    = owed_q && !blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= 1'b0;
      retry  <= 1'b0;
    end else begin
      retry <= fire;
      if (fire)         owed_q <= 1'b0;
      else if (refused) owed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/blk_cause_tracker.sv
module blk_cause_tracker #(
  parameter int unsigned NUM_CAUSES = bt_pkg::DEF_NUM_CAUSES,
  parameter int unsigned IDX_W      = 2,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned CYC_W      = 32,
  parameter int unsigned ACC_W      = 40
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CYC_W-1:0]            cycle_now,
  input  logic                        set_valid,
  input  logic [IDX_W-1:0]            set_cause,
  input  logic                        clr_valid,
  input  logic [IDX_W-1:0]            clr_cause,
  input  logic                        req_valid,
  output logic                        blocked,
  output logic                        req_ready,
  output logic                        retry,
  output logic [NUM_CAUSES-1:0]       cause_mask,
  output logic [NUM_CAUSES*CNT_W-1:0] evt_cnt,
  output logic [NUM_CAUSES*ACC_W-1:0] blk_cycles
);
  // Named internal events, visible to the bound checker.
  logic begin_evt;
  logic end_evt;
  logic refused;

  bt_mask_track #(.NUM_CAUSES(NUM_CAUSES), .IDX_W(IDX_W)) u_mask (
    .clk(clk), .rst(rst),
    .set_valid(set_valid), .set_cause(set_cause),
    .clr_valid(clr_valid), .clr_cause(clr_cause),
    .mask_q(cause_mask), .begin_evt(begin_evt), .end_evt(end_evt)
  );

  bt_cause_stats #(.NUM_CAUSES(NUM_CAUSES), .IDX_W(IDX_W), .CNT_W(CNT_W),
                   .CYC_W(CYC_W), .ACC_W(ACC_W)) u_stats (
    .clk(clk), .rst(rst), .cycle_now(cycle_now),
    .begin_evt(begin_evt), .begin_cause(set_cause),
    .end_evt(end_evt), .end_cause(clr_cause),
    .evt_cnt(evt_cnt), .blk_cycles(blk_cycles)
  );

  assign blocked   = |cause_mask;
  assign req_ready = ~blocked;

  bt_retry u_retry (
    .clk(clk), .rst(rst), .blocked(blocked), .req_valid(req_valid),
    .refused(refused), .retry(retry)
  );
endmodule

// File: rtl/blk_cause_tracker_chk.sv
module blk_cause_tracker_chk #(
  parameter int unsigned NUM_CAUSES = 3,
  parameter int unsigned IDX_W      = 2,
  parameter int unsigned CNT_W      = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        set_valid,
  input logic [IDX_W-1:0]            set_cause,
  input logic                        clr_valid,
  input logic [IDX_W-1:0]            clr_cause,
  input logic                        blocked,
  input logic                        retry,
  input logic                        refused,
  input logic                        begin_evt,
  input logic                        end_evt,
  input logic [NUM_CAUSES-1:0]       cause_mask,
  input logic [NUM_CAUSES*CNT_W-1:0] evt_cnt
);
  // R1: a valid set strobe leaves its bit set on the next cycle
  p_set_bit_r1: assert property (@(posedge clk) disable iff (rst)
    (set_valid && (set_cause < IDX_W'(NUM_CAUSES))) |=> cause_mask[$past(set_cause)]);

  // R2: a clear not overridden by a same-cause set leaves its bit low
  p_clear_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && (clr_cause < IDX_W'(NUM_CAUSES)) &&
     !(set_valid && (set_cause == clr_cause))) |=> !cause_mask[$past(clr_cause)]);

  // R3: the path only closes after a set strobe
  p_block_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(blocked) |-> $past(set_valid));

  // R4: an episode only begins from an open path with a set strobe
  p_begin_src_r4: assert property (@(posedge clk) disable iff (rst)
    begin_evt |-> (set_valid && !blocked));

  // R6: an episode only ends on a clear strobe while the path is closed
  p_end_src_r6: assert property (@(posedge clk) disable iff (rst)
    end_evt |-> (clr_valid && blocked));

  // R7: retry follows an open cycle and lasts one cycle
  p_retry_open_r7: assert property (@(posedge clk) disable iff (rst)
    retry |-> $past(!blocked));
  p_retry_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    retry |=> !retry);
  p_refuse_closed_r7: assert property (@(posedge clk) disable iff (rst)
    refused |-> blocked);

  // R8: episode counts never fall outside reset (no wrap)
  for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_mono
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (evt_cnt[g*CNT_W +: CNT_W] >= $past(evt_cnt[g*CNT_W +: CNT_W])));
  end

  // R9: reset empties the mask and silences retry
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> ((cause_mask == '0) && !retry));
endmodule

bind blk_cause_tracker blk_cause_tracker_chk #(
  .NUM_CAUSES(NUM_CAUSES), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .set_valid(set_valid), .set_cause(set_cause),
  .clr_valid(clr_valid), .clr_cause(clr_cause), .blocked(blocked),
  .retry(retry), .refused(refused), .begin_evt(begin_evt), .end_evt(end_evt),
  .cause_mask(cause_mask), .evt_cnt(evt_cnt)
);

// File: tb/blk_cause_tracker_bench.sv
module blk_cause_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 3;
  localparam int IW = 2;
  localparam int CW = 4;
  localparam int YW = 12;
  localparam int AW = 12;
  localparam int CNT_MAX = (1 << CW) - 1;
  localparam int ACC_MAX = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [YW-1:0] cycle_now = 12'hFF0;
  logic set_valid = 1'b0, clr_valid = 1'b0, req_valid = 1'b0;
  logic [IW-1:0] set_cause = '0, clr_cause = '0;
  logic blocked, req_ready, retry;
  logic [N-1:0] cause_mask;
  logic [N*CW-1:0] evt_cnt;
  logic [N*AW-1:0] blk_cycles;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // reference state
  int m_mask, m_start, m_owed, m_retry;
  int m_ev[N];
  int m_acc[N];

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_cause_tracker #(.NUM_CAUSES(N), .IDX_W(IW), .CNT_W(CW), .CYC_W(YW), .ACC_W(AW))
    u_blk_cause_tracker (
      .clk(clk), .rst(rst), .cycle_now(cycle_now),
      .set_valid(set_valid), .set_cause(set_cause),
      .clr_valid(clr_valid), .clr_cause(clr_cause), .req_valid(req_valid),
      .blocked(blocked), .req_ready(req_ready), .retry(retry),
      .cause_mask(cause_mask), .evt_cnt(evt_cnt), .blk_cycles(blk_cycles));

  function automatic int bit_of(input logic v, input int idx);
    return (v && idx < N) ? (1 << idx) : 0;
  endfunction

  function automatic int cap(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Reference update at each rising edge, from the inputs applied then.
  task automatic ref_edge();
    int sb, cb, nm, fire;
    if (rst) begin
      m_mask = 0; m_start = 0; m_owed = 0; m_retry = 0;
      for (int i = 0; i < N; i++) begin m_ev[i] = 0; m_acc[i] = 0; end
    end else begin
      sb = bit_of(set_valid, int'(set_cause));
      cb = bit_of(clr_valid, int'(clr_cause));
      nm = (m_mask & ~cb & 7) | sb;
      if (m_mask == 0 && nm != 0) begin
        m_ev[set_cause] = cap(m_ev[set_cause] + 1, CNT_MAX);
        m_start = int'(cycle_now);
      end
      if (m_mask != 0 && nm == 0)
        m_acc[clr_cause] = cap(m_acc[clr_cause] + ((int'(cycle_now) - m_start) & 12'hFFF), ACC_MAX);
      fire = (m_owed != 0 && m_mask == 0) ? 1 : 0;
      m_retry = fire;
      if (fire != 0) m_owed = 0;
      else if (req_valid && m_mask != 0) m_owed = 1;
      m_mask = nm;
    end
  endtask

  task automatic compare_all();
    chk(int'(cause_mask) == m_mask, "R1/R2 mask", int'(cause_mask), m_mask);
    chk(blocked == (m_mask != 0) && req_ready == (m_mask == 0), "R3 blocked",
        int'(blocked), int'(m_mask != 0));
    chk(int'(retry) == m_retry, "R7 retry", int'(retry), m_retry);
    for (int i = 0; i < N; i++) begin
      chk(int'(evt_cnt[i*CW +: CW]) == m_ev[i], "R4/R5/R8 episode count",
          int'(evt_cnt[i*CW +: CW]), m_ev[i]);
      chk(int'(blk_cycles[i*AW +: AW]) == m_acc[i], "R6/R8 blocked cycles",
          int'(blk_cycles[i*AW +: AW]), m_acc[i]);
    end
  endtask

  task automatic step(input logic r, input logic sv, input int sc,
                      input logic cv, input int cc, input logic rq);
    @(negedge clk);
    rst = r; set_valid = sv; set_cause = IW'(sc);
    clr_valid = cv; clr_cause = IW'(cc); req_valid = rq;
    @(posedge clk);
    ref_edge();
    #1;
    compare_all();
    cycle_now = cycle_now + 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=finished", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));

    // R9: reset state
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    chk(cause_mask == '0 && evt_cnt == '0 && blk_cycles == '0 && !retry, "R9 reset",
        int'(cause_mask), 0);

    // R1/R4: open an episode with cause 1
    step(0, 1, 1, 0, 0, 0);
    chk(cause_mask == 3'b010, "R1 set bit", int'(cause_mask), 2);
    chk(evt_cnt[1*CW +: CW] == 4'd1, "R4 episode start", int'(evt_cnt[1*CW +: CW]), 1);
    idle(3);
    // R5: second cause while closed, no new episode
    step(0, 1, 0, 0, 0, 1);
    chk(evt_cnt[0*CW +: CW] == 4'd0, "R5 no count while closed", int'(evt_cnt[0*CW +: CW]), 0);
    idle(2);
    // R2/R6: drop 1, then 0 closes episode charged to cause 0 (8 cycles long)
    step(0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 1, 0, 0);
    chk(blk_cycles[0*AW +: AW] == 12'd8, "R6 elapsed charged to closer",
        int'(blk_cycles[0*AW +: AW]), 8);
    chk(blk_cycles[1*AW +: AW] == 12'd0, "R6 other cause untouched",
        int'(blk_cycles[1*AW +: AW]), 0);
    // R7: refused request earlier leads to one retry pulse
    step(0, 0, 0, 0, 0, 0);
    chk(retry == 1'b1, "R7 retry pulse", int'(retry), 1);
    step(0, 0, 0, 0, 0, 0);
    chk(retry == 1'b0, "R7 retry single", int'(retry), 0);

    // R7: episode with no refused request gives no retry
    step(0, 1, 2, 0, 0, 0);
    step(0, 0, 0, 1, 2, 0);
    idle(2);
    chk(retry == 1'b0, "R7 no retry without refusal", int'(retry), 0);

    // R2: same-cause set and clear together, set wins
    step(0, 1, 2, 1, 2, 0);
    chk(cause_mask == 3'b100, "R2 set wins", int'(cause_mask), 4);
    step(0, 0, 0, 1, 2, 0);

    // R10: invalid index 3 ignored
    step(0, 1, 3, 0, 0, 0);
    chk(cause_mask == '0 && !blocked, "R10 invalid set ignored", int'(cause_mask), 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 3, 0);
    chk(cause_mask == 3'b001, "R10 invalid clear ignored", int'(cause_mask), 1);
    step(0, 0, 0, 1, 0, 0);

    // R8: saturate episode count of cause 2
    for (int k = 0; k < 20; k++) begin
      step(0, 1, 2, 0, 0, 0);
      step(0, 0, 0, 1, 2, 0);
    end
    chk(evt_cnt[2*CW +: CW] == 4'hF, "R8 count saturates", int'(evt_cnt[2*CW +: CW]), 15);

    // R8: long episodes saturate cause 1 accumulator
    for (int k = 0; k < 3; k++) begin
      step(0, 1, 1, 0, 0, 0);
      idle(1500);
      step(0, 0, 0, 1, 1, 0);
    end
    chk(blk_cycles[1*AW +: AW] == 12'hFFF, "R8 accumulator saturates",
        int'(blk_cycles[1*AW +: AW]), ACC_MAX);

    // random mix checked against the reference each cycle
    for (int k = 0; k < 4000; k++) begin
      step(0, ($urandom % 4) == 0, int'($urandom % 4),
              ($urandom % 3) == 0, int'($urandom % 4),
              ($urandom % 5) < 2);
    end

    // R9: reset mid-stream
    step(0, 1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 0);
    chk(cause_mask == '0 && evt_cnt == '0 && blk_cycles == '0, "R9 reset mid-run",
        int'(cause_mask), 0);
    step(0, 0, 0, 0, 0, 0);
    chk(retry == 1'b0, "R9 owed flag cleared", int'(retry), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule